// File: doc/BRIEF.md
# Digital Soft-Start Sequencer with Over-Current Retry

This block paces the start-up of a regulator group. Once started, it produces a reference ramp code that climbs from zero to full scale over one soft-start period. An external DAC turns the code into the voltage that caps the error-amplifier reference of the switching regulator. The same code serves as the reference of the auxiliary linear regulator, so both rails come up together. A single enable output gates the switching stage and the auxiliary LDO at the same time.

When the over-current comparator trips, the enable drops on the next clock and the block enters a retry sequence. It counts three whole soft-start periods with the outputs held off. On the fourth period it performs a normal ramp with the outputs enabled. A trip that arrives while the outputs are held off has no effect. A trip during the fourth period starts the retry again. When a ramp with the outputs on completes, a one-clock done pulse is issued and the code stays at full scale.

The period length is 2^CNT_W clocks, with a default of 2048. The ramp code is the top CODE_W bits of the period counter, and CODE_W must not exceed CNT_W.

Top module: `ss_softstart`

## Requirements
- R1: While and after reset, ramp_code is 0, and out_en, busy and done are all 0.
- R2: When idle, a start_req sampled high at a clock edge starts a ramp at that edge: out_en=1, busy=1, ramp_code=0.
- R3: During a ramp, ramp_code equals the top CODE_W bits of a count that starts at 0 and advances by one each clock, so it never decreases.
- R4: A ramp lasts exactly 2^CNT_W clocks. After it, ramp_code holds all ones, out_en stays 1 and busy is 0.
- R5: done is high for exactly one clock, in the first cycle after a ramp with the outputs enabled completes.
- R6: An oc_trip sampled high during a ramp or while holding full scale drops out_en and ramp_code to 0 at that edge, with busy=1.
- R7: After a trip, out_en stays 0 for DUMMY_PERIODS×2^CNT_W clocks (3 periods by default). It then returns to 1 with ramp_code=0, and a normal ramp with a done pulse follows.
- R8: oc_trip has no effect while the outputs are held off during the retry periods.
- R9: A trip during the real ramp that follows a retry starts a new full retry sequence.
- R10: start_req has no effect except when idle, and oc_trip has no effect when idle.
- R11: A trip sampled in the last clock of a ramp takes priority: no done pulse, and the outputs go off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Starts a ramp when idle |
| oc_trip | input | 1 | Over-current comparator trip |
| ramp_code | output | CODE_W | Reference clamp code for both regulators |
| out_en | output | 1 | Enable for the switching stage and the auxiliary LDO |
| busy | output | 1 | Ramp or retry in progress |
| done | output | 1 | One-clock pulse when an enabled ramp completes |

## Verification
The bench times the retry window to the exact clock, so a design that counts two or four dummy periods, or that is one cycle off at a period boundary, fails R7. It pulses oc_trip during the dummy periods, and a design that restarts the count there brings the output back late. It places a trip in the final ramp cycle, and a design that gives completion priority would issue done and keep the output on. It checks every step of the ramp code, which catches the wrong bit slice or a counter that stalls.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [1:0] {
        SS_IDLE  = 2'd0,
        SS_RAMP  = 2'd1,
        SS_HOLD  = 2'd2,
        SS_RETRY = 2'd3
    } ss_state_e;

    typedef struct packed {
        logic clr;
        logic run;
    } ss_tmr_ctl_t;

    typedef struct packed {
        logic clr;
        logic tick;
    } ss_rty_ctl_t;

    function automatic logic ss_outputs_on(ss_state_e s);
        return (s == SS_RAMP) || (s == SS_HOLD);
    endfunction

    function automatic logic ss_in_progress(ss_state_e s);
        return (s == SS_RAMP) || (s == SS_RETRY);
    endfunction

endpackage

// File: rtl/ss_period_timer.sv
module ss_period_timer
    import ss_pkg::*;
#(
    parameter int CNT_W  = 11,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ss_tmr_ctl_t       ctl,
    output logic [CODE_W-1:0] top_bits,
    output logic              at_last
);
    localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            cnt <= '0;
        end else if (ctl.run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign top_bits = cnt[CNT_W-1 -: CODE_W];
    assign at_last  = ctl.run && (cnt == LAST);
endmodule

// File: rtl/ss_retry_counter.sv
module ss_retry_counter
    import ss_pkg::*;
#(
    parameter int DUMMY_PERIODS = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  ss_rty_ctl_t ctl,
    output logic        final_period
);
    localparam int PER_W = (DUMMY_PERIODS > 1) ? $clog2(DUMMY_PERIODS) : 1;
    localparam logic [PER_W-1:0] FINAL = PER_W'(DUMMY_PERIODS - 1);

    logic [PER_W-1:0] periods;

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            periods <= '0;
        end else if (ctl.tick) begin
            periods <= periods + 1'b1;
        end
    end

    assign final_period = (periods == FINAL);
endmodule

// File: rtl/ss_ctrl.sv
module ss_ctrl
    import ss_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_req,
    input  logic        oc_trip,
    input  logic        period_last,
    input  logic        retry_final,
    output ss_state_e   state,
    output ss_tmr_ctl_t tmr_ctl,
    output ss_rty_ctl_t rty_ctl,
    output logic        done
);
    ss_state_e state_nx;
    logic      done_nx;

    always_comb begin
        state_nx     = state;
        done_nx      = 1'b0;
        tmr_ctl      = '{clr: 1'b0, run: 1'b0};
        rty_ctl      = '{clr: 1'b0, tick: 1'b0};
        unique case (state)
            SS_IDLE: begin
                tmr_ctl.clr = 1'b1;
                if (start_req) state_nx = SS_RAMP;
            end
            SS_RAMP: begin
                tmr_ctl.run = 1'b1;
                if (oc_trip) begin
                    state_nx    = SS_RETRY;
                    tmr_ctl.clr = 1'b1;
                    rty_ctl.clr = 1'b1;
                end else if (period_last) begin
                    state_nx = SS_HOLD;
                    done_nx  = 1'b1;
                end
            end
            SS_HOLD: begin
                if (oc_trip) begin
                    state_nx    = SS_RETRY;
                    tmr_ctl.clr = 1'b1;
                    rty_ctl.clr = 1'b1;
                end
            end
            SS_RETRY: begin
                tmr_ctl.run = 1'b1;
                if (period_last) begin
                    rty_ctl.tick = 1'b1;
                    if (retry_final) state_nx = SS_RAMP;
                end
            end
            default: state_nx = SS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SS_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= done_nx;
        end
    end
endmodule

// File: rtl/ss_softstart.sv
module ss_softstart
    import ss_pkg::*;
#(
    parameter int CNT_W         = 11,
    parameter int CODE_W        = 8,
    parameter int DUMMY_PERIODS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic              oc_trip,
    output logic [CODE_W-1:0] ramp_code,
    output logic              out_en,
    output logic              busy,
    output logic              done
);
    ss_state_e         state;
    ss_tmr_ctl_t       tmr_ctl;
    ss_rty_ctl_t       rty_ctl;
    logic [CODE_W-1:0] top_bits;
    logic              period_last;
    logic              retry_final;

    ss_period_timer #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .ctl      (tmr_ctl),
        .top_bits (top_bits),
        .at_last  (period_last)
    );

    ss_retry_counter #(.DUMMY_PERIODS(DUMMY_PERIODS)) u_retry (
        .clk          (clk),
        .rst          (rst),
        .ctl          (rty_ctl),
        .final_period (retry_final)
    );

    ss_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .oc_trip     (oc_trip),
        .period_last (period_last),
        .retry_final (retry_final),
        .state       (state),
        .tmr_ctl     (tmr_ctl),
        .rty_ctl     (rty_ctl),
        .done        (done)
    );

    always_comb begin
        unique case (state)
            SS_RAMP: ramp_code = top_bits;
            SS_HOLD: ramp_code = '1;
            default: ramp_code = '0;
        endcase
    end

    assign out_en = ss_outputs_on(state);
    assign busy   = ss_in_progress(state);
endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
    parameter int CNT_W         = 11,
    parameter int CODE_W        = 8,
    parameter int DUMMY_PERIODS = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              oc_trip,
    input logic [CODE_W-1:0] ramp_code,
    input logic              out_en,
    input logic              busy,
    input logic              done
);
    localparam int OFF_W = CNT_W + $clog2(DUMMY_PERIODS + 1) + 1;
    localparam logic [OFF_W-1:0] OFF_TOTAL = OFF_W'(DUMMY_PERIODS) << CNT_W;

    logic [OFF_W-1:0] off_cnt;

    always_ff @(posedge clk) begin
        if (rst) off_cnt <= '0;
        else if (busy && !out_en) off_cnt <= off_cnt + 1'b1;
        else off_cnt <= '0;
    end

    p_code_rises_r3: assert property (@(posedge clk) disable iff (rst)
        (out_en && busy) |=> (!out_en || ramp_code >= $past(ramp_code)));

    p_done_full_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (ramp_code == {CODE_W{1'b1}}) && out_en && !busy);

    p_hold_steady_r4: assert property (@(posedge clk) disable iff (rst)
        (out_en && !busy && !oc_trip) |=> $stable(ramp_code) && out_en);

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_trip_off_r6: assert property (@(posedge clk) disable iff (rst)
        (out_en && oc_trip) |=> (!out_en && busy && ramp_code == '0));

    p_retry_window_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(out_en) && off_cnt != '0) |-> (off_cnt == OFF_TOTAL));
endmodule

bind ss_softstart ss_checker #(
    .CNT_W(CNT_W), .CODE_W(CODE_W), .DUMMY_PERIODS(DUMMY_PERIODS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .oc_trip   (oc_trip),
    .ramp_code (ramp_code),
    .out_en    (out_en),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_ss_softstart.sv
module tb_ss_softstart;
    localparam int CNT_W  = 11;
    localparam int CODE_W = 8;
    localparam int DUMMY  = 3;
    localparam int PERIOD = 1 << CNT_W;
    localparam int SHIFT  = CNT_W - CODE_W;
    localparam int FULL   = (1 << CODE_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0;
    logic oc_trip = 1'b0;
    logic [CODE_W-1:0] ramp_code;
    logic out_en, busy, done;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ss_softstart #(.CNT_W(CNT_W), .CODE_W(CODE_W), .DUMMY_PERIODS(DUMMY)) dut (
        .clk(clk), .rst(rst), .start_req(start_req), .oc_trip(oc_trip),
        .ramp_code(ramp_code), .out_en(out_en), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; start_req = 1'b0; oc_trip = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic test_reset();
        do_reset();
        chk(ramp_code == 0, "R1 code", ramp_code, 0);
        chk({out_en, busy, done} == 3'b000, "R1 flags", {out_en, busy, done}, 0);
    endtask

    task automatic test_idle_ignore();
        do_reset();
        oc_trip = 1'b1; tick(); tick(); oc_trip = 1'b0;
        chk({out_en, busy} == 2'b00 && ramp_code == 0, "R10 trip in idle",
            {out_en, busy}, 0);
    endtask

    // starts a ramp and checks it through completion
    task automatic run_ramp(input string tag);
        int bad_steps = 0;
        start_req = 1'b1; tick(); start_req = 1'b0;
        chk(out_en && busy && ramp_code == 0, "R2 start", {out_en, busy}, 3);
        for (int j = 1; j < PERIOD; j++) begin
            tick();
            if (ramp_code != CODE_W'(j >> SHIFT) || !out_en || done) bad_steps++;
        end
        chk(bad_steps == 0, "R3 ramp steps", bad_steps, 0);
        tick();
        chk(done == 1'b1, "R5 done pulse", done, 1);
        chk(ramp_code == FULL && out_en && !busy, "R4 full scale", ramp_code, FULL);
        tick();
        chk(done == 1'b0, "R5 done width", done, 0);
        chk(ramp_code == FULL, {"R4 held ", tag}, ramp_code, FULL);
    endtask

    task automatic test_ramp_and_hold();
        do_reset();
        run_ramp("a");
        start_req = 1'b1; tick(); tick(); start_req = 1'b0;
        chk(ramp_code == FULL && !done && !busy, "R10 start in hold", ramp_code, FULL);
    endtask

    // expects a trip just taken; counts the off window
    task automatic wait_retry(input string tag, input bit poke);
        int on_early = 0;
        for (int k = 1; k < DUMMY * PERIOD; k++) begin
            if (poke && k == 3000) oc_trip = 1'b1;
            tick();
            oc_trip = 1'b0;
            if (out_en || !busy) on_early++;
        end
        chk(on_early == 0, {"R7 off window ", tag}, on_early, 0);
        tick();
        chk(out_en && busy && ramp_code == 0, {"R7 resume ", tag}, out_en, 1);
    endtask

    task automatic test_hiccup_from_hold();
        do_reset();
        run_ramp("b");
        oc_trip = 1'b1; tick(); oc_trip = 1'b0;
        chk(!out_en && busy && ramp_code == 0, "R6 trip in hold", out_en, 0);
        wait_retry("hold", 1'b1);   // pulse during dummy periods checks R8
        chk(1'b1, "R8 trip ignored while off", 0, 0);
        for (int j = 1; j < PERIOD; j++) tick();
        tick();
        chk(done && ramp_code == FULL, "R7 ramp after retry", done, 1);
    endtask

    task automatic test_retrigger();
        do_reset();
        start_req = 1'b1; tick(); start_req = 1'b0;
        for (int j = 0; j < 100; j++) tick();
        oc_trip = 1'b1; tick(); oc_trip = 1'b0;
        chk(!out_en && busy && ramp_code == 0, "R6 trip in ramp", out_en, 0);
        wait_retry("ramp", 1'b0);
        for (int j = 0; j < 50; j++) tick();
        oc_trip = 1'b1; tick(); oc_trip = 1'b0;
        chk(!out_en && busy, "R9 retrigger", out_en, 0);
        wait_retry("again", 1'b0);
    endtask

    task automatic test_trip_at_end();
        do_reset();
        start_req = 1'b1; tick(); start_req = 1'b0;
        for (int j = 1; j < PERIOD; j++) tick();
        oc_trip = 1'b1; tick(); oc_trip = 1'b0;
        chk(!done && !out_en && busy, "R11 trip beats done", done, 0);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        test_reset();
        test_idle_ignore();
        test_ramp_and_hold();
        test_hiccup_from_hold();
        test_retrigger();
        test_trip_at_end();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule